// File: doc/BRIEF.md
# Guest-Aware Indirect Register Router

This block sits between a hart's indirect register access port and a bank of interrupt files. Each access carries a privilege level, a virtualization flag, a guest index, a register select, an access width and optional write data. The router decides which interrupt file the access belongs to: page 0 for the hart's own level, or one of the guest pages when a virtualized supervisor access names a guest. It also sorts the select value into one of five register classes. Legal accesses go out one cycle later with a page index, a class code and a word index. Illegal accesses never reach a file. They return zero data and raise a single-cycle error.

A parameter fixes whether the instance serves machine mode (exactly one page) or supervisor mode (one page for the hart plus one page for each guest). The interrupt file storage is outside this block. The file returns read data combinationally for the forwarded access, and the router passes that data back, or zero when the access was refused.

Top module: `guest_csr_router`

## Requirements
- R1: With MACHINE_MODE=1, an access is legal only when the privilege is machine (2'b11) and the virtualization flag is 0. A legal access targets page 0. Any other privilege, or a set virtualization flag, is an error.
- R2: With MACHINE_MODE=0, any privilege other than supervisor (2'b01) is an error, including machine (2'b11) and user (2'b00).
- R3: With MACHINE_MODE=0, a supervisor access with the virtualization flag clear targets page 0, whatever value the guest index holds.
- R4: With MACHINE_MODE=0, a supervisor access with the virtualization flag set targets the page equal to the guest index. It is legal only if 0 < guest index < NUM_PAGES. The values 0 and NUM_PAGES or more are errors.
- R5: The select decode produces the class code on `fwd_class`:
  - 0x070 gives delivery enable (class 0).
  - 0x071 gives top identity (class 2).
  - 0x072 gives threshold (class 1).
  - 0x080 to 0x0BF give pending words (class 3).
  - 0x0C0 to 0x0FF give enable words (class 4).
  - Every other select value is an error.
- R6: For pending and enable words, `fwd_word` is the select value minus the base of its range (0x080 or 0x0C0). When `req_wide`=1, an odd word index is an error. The width flag has no effect on the other classes or on even words.
- R7: An illegal access produces `rsp_err`=1 for exactly one cycle and `fwd_valid`=0. `rsp_rdata` is 0 even when `file_rdata` is nonzero.
- R8: A legal access presented in cycle N produces `fwd_valid`=1 and `rsp_valid`=1 in cycle N+1. In that cycle `fwd_we`, `fwd_wdata` and `fwd_wmask` carry the request's values, and `rsp_rdata` equals `file_rdata`.
- R9: During reset and in any cycle after a cycle without `req_valid`, `rsp_valid`, `rsp_err` and `fwd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access request this cycle |
| req_priv | input | 2 | Privilege: 2'b11 machine, 2'b01 supervisor, 2'b00 user |
| req_virt | input | 1 | Virtualization flag |
| req_guest | input | GUEST_W | Guest index used under virtualization |
| req_sel | input | SEL_W | Register select |
| req_wide | input | 1 | 1 = double-width access |
| req_we | input | 1 | Write request |
| req_wdata | input | DATA_W | Write data |
| req_wmask | input | DATA_W | Write bit mask |
| fwd_valid | output | 1 | Legal access forwarded to the file |
| fwd_page | output | PAGE_W | Target page |
| fwd_class | output | 3 | Register class code |
| fwd_word | output | 6 | Word index within the pending or enable array |
| fwd_we | output | 1 | Forwarded write request |
| fwd_wdata | output | DATA_W | Forwarded write data |
| fwd_wmask | output | DATA_W | Forwarded write mask |
| file_rdata | input | DATA_W | Read data from the addressed file |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Previous request was illegal |
| rsp_rdata | output | DATA_W | Read data, zero on error |

## Verification
One request can fail both the privilege check and the select decode at the same moment, for example a user-level access with an unmapped select. In that case the two refusal paths must merge into one error pulse and no forward. The bench sends requests that fail only the privilege or guest check, requests that fail only the select or width check, and requests that fail both, while the file model drives nonzero read data. In every such case it expects exactly one `rsp_err` cycle, no `fwd_valid` and zero `rsp_rdata`. A legal access that follows right after an error must come back clean.

// File: rtl/guest_csr_router_pkg.sv
package guest_csr_router_pkg;

  localparam int WORD_W = 6;

  typedef enum logic [2:0] {
    CLS_DELIV  = 3'd0,
    CLS_THRESH = 3'd1,
    CLS_TOP    = 3'd2,
    CLS_PEND   = 3'd3,
    CLS_ENAB   = 3'd4
  } reg_class_e;

  localparam logic [1:0] PRIV_USER = 2'b00;
  localparam logic [1:0] PRIV_SUP  = 2'b01;
  localparam logic [1:0] PRIV_MACH = 2'b11;

  localparam int unsigned SEL_DELIV     = 32'h070;
  localparam int unsigned SEL_TOP       = 32'h071;
  localparam int unsigned SEL_THRESH    = 32'h072;
  localparam int unsigned SEL_PEND_BASE = 32'h080;
  localparam int unsigned SEL_ENAB_BASE = 32'h0C0;
  localparam int unsigned SEL_WORDS     = 32'd64;

endpackage

// File: rtl/rt_priv_gate.sv
module rt_priv_gate
  import guest_csr_router_pkg::*;
#(
  parameter bit MACHINE_MODE = 1'b0,
  parameter int NUM_PAGES    = 4,
  parameter int GUEST_W      = 6,
  parameter int PAGE_W       = 2
) (
  input  logic [1:0]         priv,
  input  logic               virt,
  input  logic [GUEST_W-1:0] guest,
  output logic               ok,
  output logic [PAGE_W-1:0]  page
);

  logic guest_in_range;

  always_comb begin
    guest_in_range = (guest != '0) && (32'(guest) < NUM_PAGES);
    ok   = 1'b0;
    page = '0;
    if (MACHINE_MODE) begin
      ok = (priv == PRIV_MACH) && !virt;
    end else if (priv == PRIV_SUP) begin
      if (virt) begin
        ok   = guest_in_range;
        page = guest_in_range ? guest[PAGE_W-1:0] : '0;
      end else begin
        ok = 1'b1;
      end
    end
  end

endmodule

// File: rtl/rt_sel_decode.sv
module rt_sel_decode
  import guest_csr_router_pkg::*;
#(
  parameter int SEL_W = 12
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic              wide,
  output logic              ok,
  output reg_class_e        cls,
  output logic [WORD_W-1:0] word
);

  localparam logic [SEL_W-1:0] S_DELIV  = SEL_W'(SEL_DELIV);
  localparam logic [SEL_W-1:0] S_TOP    = SEL_W'(SEL_TOP);
  localparam logic [SEL_W-1:0] S_THRESH = SEL_W'(SEL_THRESH);
  localparam logic [SEL_W-1:0] S_PBASE  = SEL_W'(SEL_PEND_BASE);
  localparam logic [SEL_W-1:0] S_EBASE  = SEL_W'(SEL_ENAB_BASE);
  localparam logic [SEL_W-1:0] S_PEND_E = SEL_W'(SEL_PEND_BASE + SEL_WORDS);
  localparam logic [SEL_W-1:0] S_ENAB_E = SEL_W'(SEL_ENAB_BASE + SEL_WORDS);

  logic [SEL_W-1:0] off;

  always_comb begin
    ok   = 1'b0;
    cls  = CLS_DELIV;
    word = '0;
    off  = '0;
    if (sel == S_DELIV) begin
      ok = 1'b1;
    end else if (sel == S_TOP) begin
      ok  = 1'b1;
      cls = CLS_TOP;
    end else if (sel == S_THRESH) begin
      ok  = 1'b1;
      cls = CLS_THRESH;
    end else if (sel >= S_PBASE && sel < S_PEND_E) begin
      off  = sel - S_PBASE;
      word = off[WORD_W-1:0];
      cls  = CLS_PEND;
      ok   = !(wide && off[0]);
    end else if (sel >= S_EBASE && sel < S_ENAB_E) begin
      off  = sel - S_EBASE;
      word = off[WORD_W-1:0];
      cls  = CLS_ENAB;
      ok   = !(wide && off[0]);
    end
  end

endmodule

// File: rtl/rt_rst_sync.sv
module rt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= (g == 0) ? 1'b1 : chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign rst_n_sync = chain[STAGES-1];

endmodule

// File: rtl/guest_csr_router.sv
module guest_csr_router
  import guest_csr_router_pkg::*;
#(
  parameter bit MACHINE_MODE = 1'b0,
  parameter int NUM_PAGES    = 4,
  parameter int GUEST_W      = 6,
  parameter int SEL_W        = 12,
  parameter int DATA_W       = 64,
  parameter int PAGE_W       = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_priv,
  input  logic               req_virt,
  input  logic [GUEST_W-1:0] req_guest,
  input  logic [SEL_W-1:0]   req_sel,
  input  logic               req_wide,
  input  logic               req_we,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [DATA_W-1:0]  req_wmask,
  output logic               fwd_valid,
  output logic [PAGE_W-1:0]  fwd_page,
  output logic [2:0]         fwd_class,
  output logic [5:0]         fwd_word,
  output logic               fwd_we,
  output logic [DATA_W-1:0]  fwd_wdata,
  output logic [DATA_W-1:0]  fwd_wmask,
  input  logic [DATA_W-1:0]  file_rdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [DATA_W-1:0]  rsp_rdata
);

  logic              rst_n_sync;
  logic              gate_ok;
  logic [PAGE_W-1:0] gate_page;
  logic              sel_ok;
  reg_class_e        sel_cls;
  logic [WORD_W-1:0] sel_word;

  logic              fwd_valid_d, rsp_valid_d, rsp_err_d, load_en;
  logic              fwd_valid_q, rsp_valid_q, rsp_err_q;
  logic [PAGE_W-1:0] page_q;
  logic [2:0]        cls_q;
  logic [WORD_W-1:0] word_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q, wmask_q;

  rt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  rt_priv_gate #(
    .MACHINE_MODE (MACHINE_MODE),
    .NUM_PAGES    (NUM_PAGES),
    .GUEST_W      (GUEST_W),
    .PAGE_W       (PAGE_W)
  ) u_gate (
    .priv  (req_priv),
    .virt  (req_virt),
    .guest (req_guest),
    .ok    (gate_ok),
    .page  (gate_page)
  );

  rt_sel_decode #(.SEL_W(SEL_W)) u_sel (
    .sel  (req_sel),
    .wide (req_wide),
    .ok   (sel_ok),
    .cls  (sel_cls),
    .word (sel_word)
  );

  always_comb begin
    rsp_valid_d = req_valid;
    fwd_valid_d = req_valid && gate_ok && sel_ok;
    rsp_err_d   = req_valid && !(gate_ok && sel_ok);
    load_en     = fwd_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      fwd_valid_q <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
    end else begin
      fwd_valid_q <= fwd_valid_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_err_q   <= rsp_err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      page_q  <= '0;
      cls_q   <= '0;
      word_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      wmask_q <= '0;
    end else if (load_en) begin
      page_q  <= gate_page;
      cls_q   <= sel_cls;
      word_q  <= sel_word;
      we_q    <= req_we;
      wdata_q <= req_wdata;
      wmask_q <= req_wmask;
    end
  end

  assign fwd_valid = fwd_valid_q;
  assign fwd_page  = page_q;
  assign fwd_class = cls_q;
  assign fwd_word  = word_q;
  assign fwd_we    = we_q && fwd_valid_q;
  assign fwd_wdata = wdata_q;
  assign fwd_wmask = wmask_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = fwd_valid_q ? file_rdata : '0;

endmodule

// File: rtl/rt_router_chk.sv
module rt_router_chk #(
  parameter bit MACHINE_MODE = 1'b0,
  parameter int NUM_PAGES    = 4,
  parameter int GUEST_W      = 6,
  parameter int SEL_W        = 12,
  parameter int DATA_W       = 64,
  parameter int PAGE_W       = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [1:0]         req_priv,
  input logic               req_virt,
  input logic [GUEST_W-1:0] req_guest,
  input logic [SEL_W-1:0]   req_sel,
  input logic               req_wide,
  input logic               fwd_valid,
  input logic [PAGE_W-1:0]  fwd_page,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic [DATA_W-1:0]  rsp_rdata
);

  logic odd_word_sel;
  assign odd_word_sel = (req_sel >= SEL_W'(12'h080)) && (req_sel <= SEL_W'(12'h0FF)) && req_sel[0];

  p_m_priv_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (MACHINE_MODE && req_valid && (req_priv != 2'b11 || req_virt)) |=> rsp_err);

  p_s_priv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!MACHINE_MODE && req_valid && req_priv != 2'b01) |=> (rsp_err && !fwd_valid));

  p_page0_nonvirt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_virt) |=> (!fwd_valid || fwd_page == '0));

  p_guest_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!MACHINE_MODE && req_valid && req_virt) |=>
      (!fwd_valid || fwd_page == $past(req_guest[PAGE_W-1:0])));

  p_wide_odd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_wide && odd_word_sel) |=> rsp_err);

  p_err_no_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (!fwd_valid && rsp_rdata == '0));

  p_rsp_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_valid && $onehot0({fwd_valid, rsp_err}) && (fwd_valid || rsp_err)));

  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_err && !fwd_valid));

endmodule

bind guest_csr_router rt_router_chk #(
  .MACHINE_MODE (MACHINE_MODE),
  .NUM_PAGES    (NUM_PAGES),
  .GUEST_W      (GUEST_W),
  .SEL_W        (SEL_W),
  .DATA_W       (DATA_W),
  .PAGE_W       (PAGE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .req_valid (req_valid),
  .req_priv  (req_priv),
  .req_virt  (req_virt),
  .req_guest (req_guest),
  .req_sel   (req_sel),
  .req_wide  (req_wide),
  .fwd_valid (fwd_valid),
  .fwd_page  (fwd_page),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata)
);

// File: tb/test_guest_csr_router.sv
module test_guest_csr_router;

  localparam logic [63:0] FILE_DATA = 64'hC3A5_5A3C_0F0F_F0F0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_priv = '0;
  logic        req_virt = 1'b0;
  logic [5:0]  req_guest = '0;
  logic [11:0] req_sel = '0;
  logic        req_wide = 1'b0;
  logic        req_we = 1'b0;
  logic [63:0] req_wdata = '0;
  logic [63:0] req_wmask = '0;
  logic [63:0] file_rdata = FILE_DATA;

  logic        fwd_valid, fwd_we, rsp_valid, rsp_err;
  logic [1:0]  fwd_page;
  logic [2:0]  fwd_class;
  logic [5:0]  fwd_word;
  logic [63:0] fwd_wdata, fwd_wmask, rsp_rdata;

  logic        m_fwd_valid, m_fwd_we, m_rsp_valid, m_rsp_err;
  logic [0:0]  m_fwd_page;
  logic [2:0]  m_fwd_class;
  logic [5:0]  m_fwd_word;
  logic [63:0] m_fwd_wdata, m_fwd_wmask, m_rsp_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  guest_csr_router #(.MACHINE_MODE(1'b0), .NUM_PAGES(4)) i_guest_csr_router (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_priv(req_priv),
    .req_virt(req_virt), .req_guest(req_guest), .req_sel(req_sel),
    .req_wide(req_wide), .req_we(req_we), .req_wdata(req_wdata),
    .req_wmask(req_wmask), .fwd_valid(fwd_valid), .fwd_page(fwd_page),
    .fwd_class(fwd_class), .fwd_word(fwd_word), .fwd_we(fwd_we),
    .fwd_wdata(fwd_wdata), .fwd_wmask(fwd_wmask), .file_rdata(file_rdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  guest_csr_router #(.MACHINE_MODE(1'b1), .NUM_PAGES(1)) i_guest_csr_router_m (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_priv(req_priv),
    .req_virt(req_virt), .req_guest(req_guest), .req_sel(req_sel),
    .req_wide(req_wide), .req_we(req_we), .req_wdata(req_wdata),
    .req_wmask(req_wmask), .fwd_valid(m_fwd_valid), .fwd_page(m_fwd_page),
    .fwd_class(m_fwd_class), .fwd_word(m_fwd_word), .fwd_we(m_fwd_we),
    .fwd_wdata(m_fwd_wdata), .fwd_wmask(m_fwd_wmask), .file_rdata(file_rdata),
    .rsp_valid(m_rsp_valid), .rsp_err(m_rsp_err), .rsp_rdata(m_rsp_rdata)
  );

  // {priv[2], virt, guest[6], sel[12], wide, exp_err, exp_page[2], exp_cls[3], exp_word[6]}
  localparam int NV = 18;
  localparam logic [33:0] VEC [NV] = '{
    {2'd1, 1'b0, 6'd0, 12'h070, 1'b0, 1'b0, 2'd0, 3'd0, 6'd0},   // R3 R5 delivery
    {2'd1, 1'b0, 6'd3, 12'h072, 1'b0, 1'b0, 2'd0, 3'd1, 6'd0},   // R3 guest ignored, threshold
    {2'd1, 1'b1, 6'd2, 12'h071, 1'b0, 1'b0, 2'd2, 3'd2, 6'd0},   // R4 guest 2, top
    {2'd1, 1'b1, 6'd3, 12'h080, 1'b0, 1'b0, 2'd3, 3'd3, 6'd0},   // R4 last guest
    {2'd1, 1'b1, 6'd4, 12'h080, 1'b0, 1'b1, 2'd0, 3'd0, 6'd0},   // R4 guest == pages
    {2'd1, 1'b1, 6'd0, 12'h070, 1'b0, 1'b1, 2'd0, 3'd0, 6'd0},   // R4 guest zero
    {2'd3, 1'b0, 6'd0, 12'h070, 1'b0, 1'b1, 2'd0, 3'd0, 6'd0},   // R2 machine priv
    {2'd0, 1'b0, 6'd0, 12'h070, 1'b0, 1'b1, 2'd0, 3'd0, 6'd0},   // R2 user priv
    {2'd1, 1'b0, 6'd0, 12'h0BF, 1'b0, 1'b0, 2'd0, 3'd3, 6'd63},  // R5 R6 last pending
    {2'd1, 1'b1, 6'd1, 12'h0C0, 1'b0, 1'b0, 2'd1, 3'd4, 6'd0},   // R5 first enable
    {2'd1, 1'b0, 6'd0, 12'h0FF, 1'b0, 1'b0, 2'd0, 3'd4, 6'd63},  // R5 last enable
    {2'd1, 1'b0, 6'd0, 12'h06F, 1'b0, 1'b1, 2'd0, 3'd0, 6'd0},   // R5 below delivery
    {2'd1, 1'b0, 6'd0, 12'h073, 1'b0, 1'b1, 2'd0, 3'd0, 6'd0},   // R5 gap
    {2'd1, 1'b0, 6'd0, 12'h100, 1'b0, 1'b1, 2'd0, 3'd0, 6'd0},   // R5 above enable
    {2'd1, 1'b0, 6'd0, 12'h082, 1'b1, 1'b0, 2'd0, 3'd3, 6'd2},   // R6 wide even
    {2'd1, 1'b0, 6'd0, 12'h0C3, 1'b1, 1'b1, 2'd0, 3'd0, 6'd0},   // R6 wide odd
    {2'd1, 1'b1, 6'd2, 12'h072, 1'b1, 1'b0, 2'd2, 3'd1, 6'd0},   // R6 wide no effect
    {2'd0, 1'b1, 6'd9, 12'h200, 1'b0, 1'b1, 2'd0, 3'd0, 6'd0}    // R7 both checks fail
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] p, input logic v, input logic [5:0] g,
                       input logic [11:0] s, input logic w, input logic we,
                       input logic [63:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_priv = p; req_virt = v; req_guest = g;
    req_sel = s; req_wide = w; req_we = we; req_wdata = wd; req_wmask = ~wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R9 reset fwd_valid", 64'(fwd_valid), 64'd0);
    chk("R9 reset rsp_err", 64'(rsp_err), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 idle after reset", 64'({rsp_valid, rsp_err, fwd_valid}), 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      logic        e;
      logic [63:0] wd;
      v  = VEC[i];
      e  = v[11];
      wd = {32'hD00D_0000, 32'(i)};
      drive(v[33:32], v[31], v[30:25], v[24:13], v[12], 1'(i % 2), wd);
      chk(e ? "R7 err flag" : "R8 err flag", 64'(rsp_err), 64'(e));
      chk(e ? "R7 no forward" : "R8 forward", 64'(fwd_valid), 64'(!e));
      chk("R8 rsp_valid", 64'(rsp_valid), 64'd1);
      chk(e ? "R7 zero data" : "R8 read data", rsp_rdata, e ? 64'd0 : FILE_DATA);
      if (!e) begin
        chk("R3 R4 page", 64'(fwd_page), 64'(v[10:9]));
        chk("R5 class", 64'(fwd_class), 64'(v[8:6]));
        chk("R6 word", 64'(fwd_word), 64'(v[5:0]));
        chk("R8 write enable", 64'(fwd_we), 64'(i % 2));
        chk("R8 write data", fwd_wdata, wd);
        chk("R8 write mask", fwd_wmask, ~wd);
      end
    end

    // R7: the error lasts one cycle only
    drive(2'd0, 1'b0, 6'd0, 12'h070, 1'b0, 1'b0, 64'd0);
    chk("R7 err pulse", 64'(rsp_err), 64'd1);
    @(negedge clk);
    chk("R7 err one cycle", 64'(rsp_err), 64'd0);
    chk("R9 idle rsp_valid", 64'(rsp_valid), 64'd0);

    // R1: machine-mode instance
    drive(2'd3, 1'b0, 6'd2, 12'h0C4, 1'b0, 1'b0, 64'd0);
    chk("R1 machine legal", 64'(m_fwd_valid), 64'd1);
    chk("R1 machine page 0", 64'(m_fwd_page), 64'd0);
    chk("R1 machine word", 64'(m_fwd_word), 64'd4);
    chk("R1 machine data", m_rsp_rdata, FILE_DATA);
    chk("R2 machine priv on supervisor file", 64'(rsp_err), 64'd1);
    drive(2'd3, 1'b1, 6'd0, 12'h070, 1'b0, 1'b0, 64'd0);
    chk("R1 machine virt refused", 64'(m_rsp_err), 64'd1);
    chk("R1 machine virt no forward", 64'(m_fwd_valid), 64'd0);
    drive(2'd1, 1'b0, 6'd0, 12'h070, 1'b0, 1'b0, 64'd0);
    chk("R1 supervisor on machine file", 64'(m_rsp_err), 64'd1);
    chk("R3 supervisor legal here", 64'(fwd_valid), 64'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule